// File: doc/BRIEF.md
# Floating-Point Exception Trap Logic

This block follows a floating-point arithmetic datapath. When an operation finishes, the block classifies the unbounded intermediate result as normal, overflowed or underflowed. It merges those conditions with the conditions the datapath reports itself and with a divide-by-zero test. The merged conditions go into a sticky exception-status byte. The block then decides whether a trap is due and, if so, which one.

For the handler, the block also builds an 80-bit extended-format exception operand. On underflow, the exponent of that operand is re-biased so that very small magnitudes still fit the 15-bit field. An underflow too deep even for that gets an all-zero exponent.

Once a trap has been reported, the block stays silent until a save strobe arrives. That strobe models the handler saving the floating-point state. The sticky status can be overwritten through a write port.

Top module: `fp_exc_trap`

## Requirements
- R1: On an operation-complete cycle with `op_is_div` and `divisor_zero` both high, the divide-by-zero status bit (bit 2) is set on the next edge.
- R2: A trap pulse is raised only for a condition that the completing operation itself produces and whose bit in `exc_enable` is 1. A raised condition with its enable bit at 0 only updates status.
- R3: On underflow to a register destination (`dest_mem`=0), the operand exponent field is the low 15 bits of the true exponent + 0x9FFF (0x3FFF + 0x6000). The mantissa is passed through unchanged.
- R4: On underflow to a memory or integer destination (`dest_mem`=1), the operand exponent field is the low 15 bits of the true exponent + 0x3FFF. The mantissa is passed through unchanged.
- R5: If the true exponent is -40959 or lower (catastrophic underflow), the operand exponent field is 0x0000 for either destination type.
- R6: Condition bits, MSB to LSB, are BSUN(7), SNAN(6), OPERR(5), OVFL(4), UNFL(3), DZ(2), INEX2(1), INEX1(0). `trap_code` is the index of the highest set bit among the enabled conditions of the operation. So an enabled UNFL suppresses an enabled inexact trap, and the inexact bits stay visible in status.
- R7: After a trap pulse, `trap_held` is 1 and no further trap pulse or operand update occurs until `save_clr`. Status still accumulates while held. A trap and `save_clr` in the same cycle leave the block held.
- R8: Status bits are sticky and accumulate by OR on each completing operation. `stat_we` replaces the whole byte with `stat_wdata` and overrides any concurrent accumulation. A synchronous reset clears status, hold, trap outputs and operand.
- R9: The operand is `{sign, exponent[14:0], mantissa[63:0]}`, registered on the edge that ends an unheld operation-complete cycle, together with `trap_valid` and `trap_code`. Without underflow the exponent field is the low 15 bits of exponent + 0x3FFF.
- R10: A true exponent below -16382 raises UNFL, and one above 16383 raises OVFL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| op_done | input | 1 | Operation-complete strobe |
| op_is_div | input | 1 | Operation is a divide |
| divisor_zero | input | 1 | Divisor is zero |
| dp_flags | input | 8 | Conditions reported by the datapath, in status bit order |
| res_sign | input | 1 | Sign of the intermediate result |
| res_exp | input | EXP_W | Unbiased two's-complement exponent of the intermediate result |
| res_mant | input | 64 | Mantissa with explicit integer bit, already rounded |
| dest_mem | input | 1 | 1 = memory or integer destination, 0 = register destination |
| exc_enable | input | 8 | Trap enable mask |
| stat_we | input | 1 | Status byte write strobe |
| stat_wdata | input | 8 | Status byte write value |
| save_clr | input | 1 | State-save strobe; releases the trap hold |
| status | output | 8 | Sticky exception status |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_code | output | 3 | Bit index of the trapping condition |
| trap_held | output | 1 | Trap reported, awaiting save |
| operand | output | 80 | Exception operand |

## Verification
The bench sweeps exponents across the edges of the normal range and of the re-biased range: -16382, -16383, -40958, -40959 and -40960, and 16383 and 16384. It does this for both destination types. An off-by-one threshold or a missed bias swap would show up as a wrong exponent field or a missing UNFL or OVFL bit.

It enables UNFL and the inexact bits together and checks that the code reports the underflow. A priority encoder wired the wrong way round would report inexact instead.

It fires operations while the block is held, and in the same cycles as `save_clr` and `stat_we`. A design that leaked a second trap, overwrote the saved operand, or let accumulation beat the write would disagree with the model on the next compare.

// File: rtl/fp_exc_trap.sv
module fp_exc_trap #(
  parameter int EXP_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_done,
  input  logic             op_is_div,
  input  logic             divisor_zero,
  input  logic [7:0]       dp_flags,
  input  logic             res_sign,
  input  logic [EXP_W-1:0] res_exp,
  input  logic [63:0]      res_mant,
  input  logic             dest_mem,
  input  logic [7:0]       exc_enable,
  input  logic             stat_we,
  input  logic [7:0]       stat_wdata,
  input  logic             save_clr,
  output logic [7:0]       status,
  output logic             trap_valid,
  output logic [2:0]       trap_code,
  output logic             trap_held,
  output logic [79:0]      operand
);
  localparam int NORM_BIAS = 16383;
  localparam int WRAP_BIAS = 16383 + 24576;
  localparam int MIN_NORM  = -16382;
  localparam int MAX_NORM  = 16383;
  localparam int CAT_LIM   = -WRAP_BIAS;

  logic signed [EXP_W+1:0] e_s;
  assign e_s = {{2{res_exp[EXP_W-1]}}, res_exp};

  logic unf, ovf, dz, cat;
  assign unf = e_s < MIN_NORM;
  assign ovf = e_s > MAX_NORM;
  assign cat = e_s <= CAT_LIM;
  assign dz  = op_is_div & divisor_zero;

  logic [7:0] cond, pend;
  assign cond = dp_flags | {3'b000, ovf, unf, dz, 2'b00};
  assign pend = cond & exc_enable;

  logic [14:0] f_norm, f_wrap, f_sel;
  assign f_norm = 15'(e_s + NORM_BIAS);
  assign f_wrap = 15'(e_s + WRAP_BIAS);
  assign f_sel  = cat ? 15'd0 : (unf && !dest_mem) ? f_wrap : f_norm;

  logic [2:0] code_n;
  always_comb begin
    code_n = 3'd0;
    for (int i = 0; i < 8; i++)
      if (pend[i]) code_n = 3'(i);
  end

  logic take, fire;
  assign take = op_done & ~trap_held;
  assign fire = take & (|pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      status     <= 8'h00;
      trap_valid <= 1'b0;
      trap_code  <= 3'd0;
      trap_held  <= 1'b0;
      operand    <= 80'd0;
    end else begin
      if (stat_we)      status <= stat_wdata;
      else if (op_done) status <= status | cond;
      trap_valid <= fire;
      trap_held  <= fire | (trap_held & ~save_clr);
      if (take) begin
        trap_code <= code_n;
        operand   <= {res_sign, f_sel, res_mant};
      end
    end
  end

  assert_dz_sets_status_R1: assert property (@(posedge clk) disable iff (rst)
    (op_done && op_is_div && divisor_zero && !stat_we) |=> status[2]);

  assert_trap_needs_op_R2: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> ($past(op_done) && !$past(trap_held)));

  assert_catastrophic_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (take && cat) |=> (operand[78:64] == 15'd0));

  assert_held_after_trap_R7: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> trap_held);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> !trap_valid);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !stat_we |=> ((status & $past(status)) == $past(status)));

  assert_operand_held_R9: assert property (@(posedge clk) disable iff (rst)
    (!op_done || trap_held) |=> $stable(operand));
endmodule

// File: tb/tb_fp_exc_trap.sv
`timescale 1ns/1ps
module tb_fp_exc_trap;
  localparam int EXP_W = 20;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst, op_done, op_is_div, divisor_zero, res_sign, dest_mem, stat_we, save_clr;
  logic [7:0] dp_flags, exc_enable, stat_wdata;
  logic [EXP_W-1:0] res_exp;
  logic [63:0] res_mant;
  logic [7:0] status;
  logic trap_valid, trap_held;
  logic [2:0] trap_code;
  logic [79:0] operand;

  fp_exc_trap #(.EXP_W(EXP_W)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  string phase = "R8 reset";
  bit done = 0;

  logic [7:0]  m_status;
  logic        m_valid, m_held;
  logic [2:0]  m_code;
  logic [79:0] m_opnd;

  task automatic chk(string what, logic [79:0] act, logic [79:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("status",     80'(status),     80'(m_status));
    chk("trap_valid", 80'(trap_valid), 80'(m_valid));
    chk("trap_code",  80'(trap_code),  80'(m_code));
    chk("trap_held",  80'(trap_held),  80'(m_held));
    chk("operand",    operand,         m_opnd);
  endtask

  task automatic model();
    int e;
    bit unf, ovf, cat;
    logic [7:0] cnd, pnd;
    logic [14:0] ef;
    bit take;
    if (rst) begin
      m_status = 0; m_valid = 0; m_code = 0; m_held = 0; m_opnd = 0;
      return;
    end
    e = int'($signed(res_exp));
    unf = e < -16382;
    ovf = e > 16383;
    cat = e <= -40959;
    cnd = dp_flags;
    if (ovf) cnd[4] = 1;
    if (unf) cnd[3] = 1;
    if (op_is_div && divisor_zero) cnd[2] = 1;
    pnd = cnd & exc_enable;
    if (cat) ef = 0;
    else if (unf && !dest_mem) ef = 15'((e + 40959) % 32768);
    else ef = 15'(e + 16383);
    take = op_done && !m_held;
    if (stat_we) m_status = stat_wdata;
    else if (op_done) m_status = m_status | cnd;
    m_valid = take && (pnd != 0);
    if (take) begin
      for (int i = 7; i >= 0; i--)
        if (pnd[i]) begin m_code = 3'(i); break; end
      if (pnd == 0) m_code = 0;
      m_opnd = {res_sign, ef, res_mant};
    end
    m_held = m_valid || (m_held && !save_clr);
  endtask

  task automatic cyc(bit op, bit dv, bit zr, logic [7:0] fl, int e, bit mem,
                     logic [7:0] en, bit we = 0, logic [7:0] wd = 0, bit clr = 0);
    @(negedge clk);
    compare();
    op_done = op; op_is_div = dv; divisor_zero = zr; dp_flags = fl;
    res_exp = EXP_W'(e); dest_mem = mem; exc_enable = en;
    stat_we = we; stat_wdata = wd; save_clr = clr;
    res_sign = 1'($urandom); res_mant = {$urandom, $urandom};
    model();
  endtask

  task automatic release_and_clear();
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 8'h00, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL [watchdog] run hung actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int edges[10] = '{-16382, -16383, -40958, -40959, -40960, 16383, 16384, 0, -30000, -60000};
    rst = 1; op_done = 0; op_is_div = 0; divisor_zero = 0; dp_flags = 0;
    res_sign = 0; res_exp = 0; res_mant = 0; dest_mem = 0; exc_enable = 0;
    stat_we = 0; stat_wdata = 0; save_clr = 0;
    model();
    repeat (3) @(negedge clk);
    @(negedge clk); compare();
    rst = 0; model();

    phase = "R1 divide by zero, masked";
    cyc(1, 1, 1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 0, 0);
    phase = "R2 enabled DZ trap";
    cyc(1, 1, 1, 0, 0, 0, 8'h04);
    cyc(0, 0, 0, 0, 0, 0, 0);
    phase = "R7 held, ops ignored for trap and operand";
    cyc(1, 0, 0, 8'h80, 16384, 0, 8'hFF);
    cyc(1, 0, 0, 0, -20000, 1, 8'hFF, 0, 0, 1);
    cyc(1, 0, 0, 8'h01, 5, 0, 8'h01);
    release_and_clear();

    phase = "R3 R4 R5 R10 exponent edges";
    foreach (edges[k]) begin
      cyc(1, 0, 0, 0, edges[k], 0, 8'h00);
      cyc(1, 0, 0, 0, edges[k], 1, 8'h00);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 8'h00);

    phase = "R6 underflow beats inexact";
    cyc(1, 0, 0, 8'h03, -20000, 0, 8'h0B);
    cyc(0, 0, 0, 0, 0, 0, 0);
    release_and_clear();
    phase = "R6 BSUN beats everything";
    cyc(1, 1, 1, 8'hE3, 20000, 1, 8'hFF);
    cyc(0, 0, 0, 0, 0, 0, 0);
    release_and_clear();

    phase = "R8 write overrides accumulate";
    cyc(1, 0, 0, 8'h20, 0, 0, 8'h00, 1, 8'h41);
    cyc(1, 0, 0, 8'h02, 0, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 0, 0);

    phase = "R9 R2 random traffic";
    for (int n = 0; n < 3000; n++) begin
      int e;
      int r = int'($urandom_range(0, 9));
      if (r < 5) e = edges[$urandom_range(0, 9)] + int'($urandom_range(0, 2)) - 1;
      else e = int'($urandom_range(0, 140000)) - 80000;
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
          8'($urandom) & 8'($urandom) & 8'($urandom), e, 1'($urandom),
          8'($urandom) & 8'($urandom),
          $urandom_range(0, 15) == 0, 8'($urandom), $urandom_range(0, 3) == 0);
    end
    phase = "R8 reset mid-run";
    @(negedge clk); compare();
    rst = 1; model();
    @(negedge clk); compare();
    rst = 0; model();
    cyc(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); compare();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule